// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one character into an asynchronous serial frame on a single output line. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity slot, then a high stop period. The character length, the parity rule and the stop length are chosen per character through configuration inputs. The block samples these inputs, together with the data byte, in the cycle it accepts the character.

Timing comes from an external enable pulse that arrives sixteen times per bit period. The block contains no rate generator. Every full bit holds the line for sixteen of these pulses. A one-and-a-half stop period holds it for twenty-four. Characters are offered with a valid/ready handshake. Ready rises only once the stop period has ended, and a character accepted in that cycle starts on the following pulse, so frames can follow each other with no gap.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, the line is 1, ready_o is 1 and busy_o is 0.
- R2: A character is accepted on a clock edge where valid_i and ready_o are both 1. From the next cycle busy_o is 1, and the line stays 1 until the next sampled tick. That tick drives the start bit, a 0 held for 16 ticks.
- R3: Data bits follow the start bit, least significant bit first, 16 ticks each. len_i selects the count: 00 = 5, 01 = 7, 10 or 11 = 8.
- R4: par_i 001 selects even parity and 010 selects odd parity. Each is computed over the selected data bits only, and its slot follows the last data bit for 16 ticks. Even makes the total count of ones in data plus parity even. Odd makes it odd.
- R5: par_i 011 (mark) drives the parity slot at 1. par_i 100 (space) drives it at 0. Codes 000, 101, 110 and 111 insert no parity slot.
- R6: The stop period holds the line at 1 for 16 ticks when stop_i is 00, 24 ticks when it is 01, and 32 ticks when it is 10 or 11.
- R7: ready_o returns to 1, and busy_o to 0, in the cycle after the tick that completes the stop period. A frame with 8 data bits, parity and a 2-bit stop spans exactly 192 ticks (12 bit times).
- R8: Configuration and data inputs are used only at acceptance. Changing them, or holding valid_i high, while busy_o is 1 does not change the frame in progress.
- R9: A character offered in the first cycle that ready_o is 1 is accepted at once, and its start bit begins on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable at 16 times the bit rate |
| len_i | input | 2 | Character length code |
| par_i | input | 3 | Parity mode code |
| stop_i | input | 2 | Stop length code |
| data_i | input | DATA_W | Character to send |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Block is idle and can accept |
| txd_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
Every result is counted in ticks from acceptance. The line holds 1 until the first tick after the accepting edge. Tick j, counted from 0, then sets the level the model computes for slot j/16. ready_o is due in the cycle after tick number (16 × (1 + data + parity) + stop length). The bench tracks which clock edges carried a tick and checks the outputs at the falling edge after each one, once the registered state has settled. It sweeps every length, parity and stop code while scrambling the inputs during each frame. It offers the next character in the first ready cycle.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;

    // character length codes
    localparam logic [1:0] LEN_FIVE  = 2'b00;
    localparam logic [1:0] LEN_SEVEN = 2'b01;

    // parity mode codes
    localparam logic [2:0] PAR_EVEN  = 3'b001;
    localparam logic [2:0] PAR_ODD   = 3'b010;
    localparam logic [2:0] PAR_MARK  = 3'b011;
    localparam logic [2:0] PAR_SPACE = 3'b100;

    // stop length codes
    localparam logic [1:0] STOP_ONE  = 2'b00;
    localparam logic [1:0] STOP_HALF = 2'b01;

endpackage

// File: rtl/tx_format_dec.sv
module tx_format_dec
    import tx_frame_pkg::*;
#(
    parameter int OVS = 16,
    parameter int CW  = 5,
    parameter int NW  = 4
) (
    input  logic [1:0]    len_code,
    input  logic [1:0]    stop_code,
    output logic [NW-1:0] nbits,
    output logic [CW-1:0] stop_last
);
    localparam int STOP1  = OVS;
    localparam int STOP15 = OVS + OVS / 2;
    localparam int STOP2  = 2 * OVS;

    always_comb begin
        case (len_code)
            LEN_FIVE:  nbits = NW'(5);
            LEN_SEVEN: nbits = NW'(7);
            default:   nbits = NW'(8);
        endcase
        case (stop_code)
            STOP_ONE:  stop_last = CW'(STOP1 - 1);
            STOP_HALF: stop_last = CW'(STOP15 - 1);
            default:   stop_last = CW'(STOP2 - 1);
        endcase
    end
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen
    import tx_frame_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NW     = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [NW-1:0]     nbits,
    input  logic [2:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    logic [DATA_W-1:0] used;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign used[i] = data[i] & (NW'(i) < nbits);
    end

    always_comb begin
        par_en = 1'b1;
        case (mode)
            PAR_EVEN:  par_bit = ^used;
            PAR_ODD:   par_bit = ~(^used);
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default: begin
                par_en  = 1'b0;
                par_bit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [1:0]        len_i,
    input  logic [2:0]        par_i,
    input  logic [1:0]        stop_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              txd_o,
    output logic              busy_o
);
    localparam int CW = $clog2(2 * OVS);
    localparam int NW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

    typedef enum logic [2:0] {
        S_IDLE, S_ARM, S_START, S_DATA, S_PAR, S_STOP
    } st_e;

    typedef struct packed {
        st_e               st;
        logic [CW-1:0]     cnt;
        logic [NW-1:0]     idx;
        logic [NW-1:0]     nbits;
        logic [CW-1:0]     stop_last;
        logic              par_en;
        logic              par_bit;
        logic [DATA_W-1:0] sh;
    } reg_t;

    localparam reg_t RESET_VAL = '{
        st: S_IDLE, cnt: '0, idx: '0, nbits: '0,
        stop_last: '0, par_en: 1'b0, par_bit: 1'b0, sh: '0
    };

    reg_t r_d, r_q;

    logic [NW-1:0] dec_nbits;
    logic [CW-1:0] dec_stop_last;
    logic          dec_par_en;
    logic          dec_par_bit;

    tx_format_dec #(.OVS(OVS), .CW(CW), .NW(NW)) u_fmt (
        .len_code  (len_i),
        .stop_code (stop_i),
        .nbits     (dec_nbits),
        .stop_last (dec_stop_last)
    );

    tx_parity_gen #(.DATA_W(DATA_W), .NW(NW)) u_par (
        .data    (data_i),
        .nbits   (dec_nbits),
        .mode    (par_i),
        .par_en  (dec_par_en),
        .par_bit (dec_par_bit)
    );

    logic accept, bit_end;
    assign accept  = valid_i && (r_q.st == S_IDLE);
    assign bit_end = tick_i && (r_q.cnt == BIT_LAST);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (accept) begin
                    r_d.st        = S_ARM;
                    r_d.sh        = data_i;
                    r_d.nbits     = dec_nbits;
                    r_d.stop_last = dec_stop_last;
                    r_d.par_en    = dec_par_en;
                    r_d.par_bit   = dec_par_bit;
                    r_d.cnt       = '0;
                    r_d.idx       = '0;
                end
            end
            S_ARM: begin
                if (tick_i) begin
                    r_d.st  = S_START;
                    r_d.cnt = '0;
                end
            end
            S_START: begin
                if (bit_end) begin
                    r_d.st  = S_DATA;
                    r_d.cnt = '0;
                    r_d.idx = '0;
                end else if (tick_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_DATA: begin
                if (bit_end) begin
                    r_d.cnt = '0;
                    r_d.sh  = r_q.sh >> 1;
                    if (r_q.idx == r_q.nbits - 1'b1) begin
                        r_d.st = r_q.par_en ? S_PAR : S_STOP;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else if (tick_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_PAR: begin
                if (bit_end) begin
                    r_d.st  = S_STOP;
                    r_d.cnt = '0;
                end else if (tick_i) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_STOP: begin
                if (tick_i) begin
                    if (r_q.cnt == r_q.stop_last) begin
                        r_d.st  = S_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= RESET_VAL;
        else         r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            S_START: txd_o = 1'b0;
            S_DATA:  txd_o = r_q.sh[0];
            S_PAR:   txd_o = r_q.par_bit;
            default: txd_o = 1'b1;
        endcase
    end

    assign ready_o = (r_q.st == S_IDLE);
    assign busy_o  = !ready_o;

    // R1
    idle_line_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> txd_o);

    // R2
    accept_holds_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> (busy_o && txd_o));

    // R2
    start_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(txd_o) |-> $past(tick_i));

    // R8
    no_tick_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !(valid_i && ready_o)) |=> ($stable(txd_o) && $stable(busy_o)));

    // R7
    end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> $past(tick_i));

    // R3
    bit_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != S_STOP) |-> (r_q.cnt <= BIT_LAST));

    // R6
    stop_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_STOP) |-> (r_q.cnt <= r_q.stop_last));

endmodule

// File: tb/tb_async_frame_tx.sv
`timescale 1ns/100ps
module tb_async_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] len_c = 2'b00;
    logic [2:0] par_c = 3'b000;
    logic [1:0] stop_c = 2'b00;
    logic [7:0] data = 8'h00;
    logic       valid = 1'b0;
    logic       ready, txd, busy;
    int         n_tests = 0;
    int         n_fail = 0;

    always #2.5 clk = ~clk;

    async_frame_tx #(.DATA_W(8), .OVS(16)) dut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .len_i(len_c), .par_i(par_c), .stop_i(stop_c),
        .data_i(data), .valid_i(valid),
        .ready_o(ready), .txd_o(txd), .busy_o(busy)
    );

    // tick on every third clock edge, changed just after the edge
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk);
            #1;
            tc = (tc + 1) % 3;
            tick = (tc == 0);
        end
    end

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic logic exp_level(int j, int n, logic pe, logic pb, logic [7:0] d);
        int s = j / 16;
        if (s == 0) return 1'b0;
        if (s <= n) return d[s-1];
        if (pe && s == n + 1) return pb;
        return 1'b1;
    endfunction

    task automatic send(input int len, input int par, input int stp, input logic [7:0] d);
        int n, sl, tt, ones, k;
        logic pe, pb, pend;
        string tag;
        n  = (len == 0) ? 5 : (len == 1) ? 7 : 8;
        sl = (stp == 0) ? 16 : (stp == 1) ? 24 : 32;
        pe = (par >= 1 && par <= 4);
        ones = 0;
        for (int i = 0; i < n; i++) ones += d[i];
        case (par)
            1: pb = ones[0];
            2: pb = ~ones[0];
            3: pb = 1'b1;
            default: pb = 1'b0;
        endcase
        tt = 16 * (1 + n + (pe ? 1 : 0)) + sl;
        while (!ready) @(negedge clk);
        len_c = 2'(len); par_c = 3'(par); stop_c = 2'(stp); data = d; valid = 1'b1;
        @(negedge clk);
        // R8: scramble inputs and keep offering while busy
        len_c = ~len_c; par_c = par_c ^ 3'b101; stop_c = ~stop_c; data = ~d;
        // R2 / R9: accepted, line still high before the first tick
        check("R2/R9", {busy, ready, txd}, 3'b101);
        pend = tick;
        k = 0;
        while (1) begin
            @(negedge clk);
            if (pend) begin
                if (k < tt) begin
                    int s = k / 16;
                    if (s == 0) tag = "R2";
                    else if (s <= n) tag = "R3/R8";
                    else if (pe && s == n + 1) tag = (par <= 2) ? "R4" : "R5";
                    else tag = "R6";
                    check(tag, {busy, ready, txd}, {2'b10, exp_level(k, n, pe, pb, d)});
                    k++;
                end else begin
                    // R7: ready returns after exactly tt ticks
                    check("R7", {busy, ready, txd}, 3'b011);
                    break;
                end
            end
            pend = tick;
        end
    endtask

    initial begin
        #5_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {busy, ready, txd}, 3'b011);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1", {busy, ready, txd}, 3'b011);
        // R7: 8 data, even parity, 2 stop = 192 ticks
        send(2, 1, 2, 8'hB7);
        // R5: mark parity with 7 bits, then 8N1 with the top bit high
        send(1, 3, 0, 8'h41);
        send(2, 0, 0, 8'hC1);
        send(1, 4, 0, 8'h41);
        // sweep of every code, back to back (R9)
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 8; p++)
                for (int s = 0; s < 4; s++)
                    send(l, p, s, 8'(8'h5A ^ (l * 37 + p * 11 + s * 3)));
        valid = 1'b0;
        repeat (100) @(negedge clk);
        // R1: idle after the last frame with no valid
        check("R1", {busy, ready, txd}, 3'b011);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule